// File: doc/BRIEF.md
# GPIO Port Controller with Register Views

This block drives one general-purpose I/O port of up to 32 pins from a simple synchronous register bus. It keeps three pieces of state: an output latch that feeds the pin output values, a direction register that feeds the pin output enables, and a mask register that narrows the masked port view. Software can reach the same state through several address views. Each pin has its own byte alias and its own word alias. The whole port can be read or written raw, or through the mask. Set, clear and toggle strobes with write-one semantics exist for both the output latch and the direction register.

Reads are registered: the data for a read appears on the read-data port one clock after the read enable, and the port returns zero in any cycle that follows no read. The external pin levels pass through a two-flop synchroniser before they reach any read path. A pin configured as an output reads back its own latch bit. A pin configured as an input reads the synchronised external level.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset the output latch, direction register and mask register are all zero, so `pin_out` and `pin_oe` are 0 and reads of the direction, mask and set views return 0.
- R2: The per-pin byte alias for pin n sits at byte address n (0..31). A write with nonzero data bits [7:0] sets latch bit n, and a write with zero in bits [7:0] clears it. A read returns 1 when the pin level is high and 0 when it is low.
- R3: The per-pin word alias for pin n sits at address 0x1000 + 4*n. A write with any nonzero data sets latch bit n, and a write of zero clears it. A read returns all ones when the pin level is high and all zeros when it is low.
- R4: The direction register at 0x2000 is read and written whole. A 1 bit makes that pin an output, and `pin_oe` equals the register.
- R5: The raw port view at 0x2100 writes all latch bits whatever the mask holds. A read of it returns the pin levels, where the level of bit n is latch bit n when direction bit n is 1 and the synchronised input bit n otherwise.
- R6: A change on `pin_in` is not seen by a read whose read enable is taken in the same cycle as the change. It is seen by a read issued two or more cycles later.
- R7: The mask register at 0x2080 is read and written whole. A write to the masked view at 0x2180 updates only the latch bits whose mask bit is 0. A read of the masked view returns the pin levels with every masked (1) bit forced to 0.
- R8: A write to 0x2200 sets every latch bit written as 1 and leaves the rest unchanged. A read of 0x2200 returns the output latch, not the pin levels.
- R9: A write to 0x2280 clears, and a write to 0x2300 inverts, every latch bit written as 1. Other bits are unchanged. Reads of both return 0.
- R10: Writes to 0x2380, 0x2400 and 0x2480 set, clear and invert the direction bits written as 1. Reads of all three return 0.
- R11: A write to an unmapped address changes no state, and a read of it returns 0. Unmapped addresses include byte addresses above 31, misaligned word aliases, non-zero offsets inside a control slot, and anything at 0x2500 or above.
- R12: Read data appears one cycle after the read enable, and `bus_rdata` is 0 in every cycle that follows a cycle without a read enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | AW (14) | Byte address of the access |
| bus_wdata | input | NPINS (32) | Write data |
| bus_we | input | 1 | Write enable |
| bus_re | input | 1 | Read enable |
| bus_rdata | output | NPINS (32) | Registered read data |
| pin_in | input | NPINS (32) | External pin levels, asynchronous |
| pin_out | output | NPINS (32) | Output latch driven to the pins |
| pin_oe | output | NPINS (32) | Output enables (direction register) |

## Verification
The hardest case to reach from the ports is a read that races a change on the external inputs. The bench handles it by changing `pin_in` on the same falling edge on which it raises the read enable for the raw view, so the sampled read data must still show the old level, and then repeats the read two cycles later. The masked view is also hard to reach because it needs latch, mask and direction to line up. The bench first loads the latch through the raw view, which ignores the mask, and then reads back through the masked view with all pins set as outputs. That way every forced-zero bit is a bit that is really set in the latch.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  typedef enum logic [3:0] {
    RK_NONE,
    RK_BYTE,
    RK_WORD,
    RK_DIR,
    RK_MASK,
    RK_LEVEL,
    RK_MLEVEL,
    RK_SET,
    RK_CLR,
    RK_TGL,
    RK_DSET,
    RK_DCLR,
    RK_DTGL
  } reg_kind_e;

  // Control slots are 128 bytes apart, starting at 0x2000
  localparam int unsigned CTRL_STRIDE_LG = 7;
  localparam logic [15:0] OFS_DIR    = 16'h2000;
  localparam logic [15:0] OFS_MASK   = 16'h2080;
  localparam logic [15:0] OFS_LEVEL  = 16'h2100;
  localparam logic [15:0] OFS_MLEVEL = 16'h2180;
  localparam logic [15:0] OFS_SET    = 16'h2200;
  localparam logic [15:0] OFS_CLR    = 16'h2280;
  localparam logic [15:0] OFS_TGL    = 16'h2300;
  localparam logic [15:0] OFS_DSET   = 16'h2380;
  localparam logic [15:0] OFS_DCLR   = 16'h2400;
  localparam logic [15:0] OFS_DTGL   = 16'h2480;

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_pkg::*;
#(
  parameter int AW = 14,
  parameter int PW = 5
) (
  input  logic [AW-1:0] addr,
  output reg_kind_e     kind,
  output logic [PW-1:0] pin
);

  localparam int RW = AW - 12;
  localparam int SW = 12 - CTRL_STRIDE_LG;

  logic [RW-1:0] region;
  logic [SW-1:0] slot;

  assign region = addr[AW-1:12];
  assign slot   = addr[11:CTRL_STRIDE_LG];

  always_comb begin
    kind = RK_NONE;
    pin  = '0;
    if (region == RW'(0)) begin
      if (addr[11:PW] == '0) begin
        kind = RK_BYTE;
        pin  = addr[PW-1:0];
      end
    end else if (region == RW'(1)) begin
      if ((addr[11:PW+2] == '0) && (addr[1:0] == 2'b00)) begin
        kind = RK_WORD;
        pin  = addr[PW+1:2];
      end
    end else if ((region == RW'(2)) && (addr[CTRL_STRIDE_LG-1:0] == '0)) begin
      case (slot)
        SW'(0):  kind = RK_DIR;
        SW'(1):  kind = RK_MASK;
        SW'(2):  kind = RK_LEVEL;
        SW'(3):  kind = RK_MLEVEL;
        SW'(4):  kind = RK_SET;
        SW'(5):  kind = RK_CLR;
        SW'(6):  kind = RK_TGL;
        SW'(7):  kind = RK_DSET;
        SW'(8):  kind = RK_DCLR;
        SW'(9):  kind = RK_DTGL;
        default: kind = RK_NONE;
      endcase
    end
  end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[s] <= '0;
        else     stg[s] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[s] <= '0;
        else     stg[s] <= stg[s-1];
      end
    end
  end

  assign dout = stg[STAGES-1];

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_pkg::*;
#(
  parameter int NP = 32,
  parameter int PW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  reg_kind_e     kind,
  input  logic [PW-1:0] pin,
  input  logic [NP-1:0] wdata,
  output logic [NP-1:0] lat_q,
  output logic [NP-1:0] dir_q,
  output logic [NP-1:0] mask_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_q  <= '0;
      dir_q  <= '0;
      mask_q <= '0;
    end else if (wr_en) begin
      case (kind)
        RK_BYTE:   lat_q[pin] <= |wdata[7:0];
        RK_WORD:   lat_q[pin] <= |wdata;
        RK_DIR:    dir_q      <= wdata;
        RK_MASK:   mask_q     <= wdata;
        RK_LEVEL:  lat_q      <= wdata;
        RK_MLEVEL: lat_q      <= (lat_q & mask_q) | (wdata & ~mask_q);
        RK_SET:    lat_q      <= lat_q | wdata;
        RK_CLR:    lat_q      <= lat_q & ~wdata;
        RK_TGL:    lat_q      <= lat_q ^ wdata;
        RK_DSET:   dir_q      <= dir_q | wdata;
        RK_DCLR:   dir_q      <= dir_q & ~wdata;
        RK_DTGL:   dir_q      <= dir_q ^ wdata;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/gpio_rd_mux.sv
module gpio_rd_mux
  import gpio_pkg::*;
#(
  parameter int NP = 32,
  parameter int PW = 5
) (
  input  reg_kind_e     kind,
  input  logic [PW-1:0] pin,
  input  logic [NP-1:0] lat,
  input  logic [NP-1:0] dir,
  input  logic [NP-1:0] mask,
  input  logic [NP-1:0] sync_in,
  output logic [NP-1:0] rd_val
);

  logic [NP-1:0] level;

  assign level = (dir & lat) | (~dir & sync_in);

  always_comb begin
    case (kind)
      RK_BYTE:   rd_val = NP'(level[pin]);
      RK_WORD:   rd_val = {NP{level[pin]}};
      RK_DIR:    rd_val = dir;
      RK_MASK:   rd_val = mask;
      RK_LEVEL:  rd_val = level;
      RK_MLEVEL: rd_val = level & ~mask;
      RK_SET:    rd_val = lat;
      default:   rd_val = '0;
    endcase
  end

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_pkg::*;
#(
  parameter int NPINS       = 32,
  parameter int AW          = 14,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AW-1:0]    bus_addr,
  input  logic [NPINS-1:0] bus_wdata,
  input  logic             bus_we,
  input  logic             bus_re,
  output logic [NPINS-1:0] bus_rdata,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe
);

  localparam int PW = $clog2(NPINS);

  reg_kind_e        kind;
  logic [PW-1:0]    pin_idx;
  logic [NPINS-1:0] lat_q;
  logic [NPINS-1:0] dir_q;
  logic [NPINS-1:0] mask_q;
  logic [NPINS-1:0] sync_q;
  logic [NPINS-1:0] rd_val;
  logic [NPINS-1:0] rdata_q;

  gpio_addr_decode #(.AW(AW), .PW(PW)) u_dec (
    .addr (bus_addr),
    .kind (kind),
    .pin  (pin_idx)
  );

  gpio_in_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (pin_in),
    .dout (sync_q)
  );

  gpio_port_regs #(.NP(NPINS), .PW(PW)) u_regs (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (bus_we),
    .kind   (kind),
    .pin    (pin_idx),
    .wdata  (bus_wdata),
    .lat_q  (lat_q),
    .dir_q  (dir_q),
    .mask_q (mask_q)
  );

  gpio_rd_mux #(.NP(NPINS), .PW(PW)) u_rmux (
    .kind    (kind),
    .pin     (pin_idx),
    .lat     (lat_q),
    .dir     (dir_q),
    .mask    (mask_q),
    .sync_in (sync_q),
    .rd_val  (rd_val)
  );

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (bus_re) rdata_q <= rd_val;
    else             rdata_q <= '0;
  end

  assign bus_rdata = rdata_q;
  assign pin_out   = lat_q;
  assign pin_oe    = dir_q;

endmodule

// File: rtl/gpio_port_ctrl_chk.sv
module gpio_port_ctrl_chk
  import gpio_pkg::*;
#(
  parameter int NPINS = 32,
  parameter int AW    = 14
) (
  input logic             clk,
  input logic             rst,
  input logic [AW-1:0]    bus_addr,
  input logic [NPINS-1:0] bus_wdata,
  input logic             bus_we,
  input logic             bus_re,
  input logic [NPINS-1:0] bus_rdata,
  input logic [NPINS-1:0] pin_out,
  input logic [NPINS-1:0] pin_oe,
  input logic [NPINS-1:0] mask
);

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pin_out == '0) && (pin_oe == '0) && (bus_rdata == '0));

  // R12
  idle_rdata_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_re |=> (bus_rdata == '0));

  // R2
  latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_we |=> $stable(pin_out));

  // R4
  dir_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_we |=> $stable(pin_oe));

  // R8
  set_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == AW'(OFS_SET)) |=>
      ((pin_out & $past(bus_wdata)) == $past(bus_wdata)) &&
      (($past(pin_out) & ~pin_out) == '0));

  // R9
  clr_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == AW'(OFS_CLR)) |=>
      ((pin_out & $past(bus_wdata)) == '0) &&
      ((pin_out & ~$past(pin_out)) == '0));

  // R9
  clr_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_re && bus_addr == AW'(OFS_CLR)) |=> (bus_rdata == '0));

  // R7
  masked_write_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == AW'(OFS_MLEVEL)) |=>
      (((pin_out ^ $past(pin_out)) & $past(mask)) == '0));

  // R10
  dirset_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == AW'(OFS_DSET)) |=>
      ((pin_oe & $past(bus_wdata)) == $past(bus_wdata)) && $stable(pin_out));

endmodule

bind gpio_port_ctrl gpio_port_ctrl_chk #(.NPINS(NPINS), .AW(AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_we    (bus_we),
  .bus_re    (bus_re),
  .bus_rdata (bus_rdata),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .mask      (mask_q)
);

// File: tb/gpio_port_ctrl_tb.sv
module gpio_port_ctrl_tb;

  localparam int NP = 32;
  localparam int AW = 14;

  localparam logic [AW-1:0] A_DIR    = 14'h2000;
  localparam logic [AW-1:0] A_MASK   = 14'h2080;
  localparam logic [AW-1:0] A_LEVEL  = 14'h2100;
  localparam logic [AW-1:0] A_MLEVEL = 14'h2180;
  localparam logic [AW-1:0] A_SET    = 14'h2200;
  localparam logic [AW-1:0] A_CLR    = 14'h2280;
  localparam logic [AW-1:0] A_TGL    = 14'h2300;
  localparam logic [AW-1:0] A_DSET   = 14'h2380;
  localparam logic [AW-1:0] A_DCLR   = 14'h2400;
  localparam logic [AW-1:0] A_DTGL   = 14'h2480;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic [NP-1:0] bus_wdata = '0;
  logic          bus_we = 1'b0;
  logic          bus_re = 1'b0;
  logic [NP-1:0] bus_rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out;
  logic [NP-1:0] pin_oe;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  gpio_port_ctrl #(.NPINS(NP), .AW(AW)) u_dut (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .bus_re    (bus_re),
    .bus_rdata (bus_rdata),
    .pin_in    (pin_in),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe)
  );

  task automatic chk(input string req, input logic [NP-1:0] act, input logic [NP-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [NP-1:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = d;
    bus_we    = 1'b1;
    @(negedge clk);
    bus_we    = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [NP-1:0] d);
    @(negedge clk);
    bus_addr = a;
    bus_re   = 1'b1;
    @(negedge clk);
    d      = bus_rdata;
    bus_re = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [NP-1:0] v;
    chk("R1 pin_out", pin_out, '0);
    chk("R1 pin_oe", pin_oe, '0);
    chk("R1 rdata", bus_rdata, '0);
    rd(A_DIR, v);  chk("R1 dir read", v, '0);
    rd(A_MASK, v); chk("R1 mask read", v, '0);
    rd(A_SET, v);  chk("R1 latch read", v, '0);
  endtask

  task automatic t_byte();
    logic [NP-1:0] v;
    wr(14'h0005, 32'h80);
    chk("R2 byte set", pin_out, 32'h20);
    wr(A_DSET, 32'h20);
    rd(14'h0005, v); chk("R2 byte read high", v, 32'h1);
    wr(14'h0005, 32'h100);
    chk("R2 byte upper bits clear", pin_out, 32'h0);
    rd(14'h0005, v); chk("R2 byte read low", v, 32'h0);
    pin_in = 32'h80;
    settle();
    rd(14'h0007, v); chk("R2 byte input pin", v, 32'h1);
  endtask

  task automatic t_word();
    logic [NP-1:0] v;
    wr(14'h1030, 32'h10);
    chk("R3 word set", pin_out, 32'h1000);
    wr(A_DSET, 32'h1000);
    rd(14'h1030, v); chk("R3 word read ones", v, 32'hFFFF_FFFF);
    wr(14'h1030, 32'h0);
    rd(14'h1030, v); chk("R3 word read zeros", v, 32'h0);
    rd(14'h101C, v); chk("R3 word input pin", v, 32'hFFFF_FFFF);
  endtask

  task automatic t_dir();
    logic [NP-1:0] v;
    wr(A_DIR, 32'hA5A5_0F0F);
    chk("R4 pin_oe", pin_oe, 32'hA5A5_0F0F);
    rd(A_DIR, v); chk("R4 dir read", v, 32'hA5A5_0F0F);
  endtask

  task automatic t_raw();
    logic [NP-1:0] v;
    wr(A_MASK, 32'hFFFF_0000);
    wr(A_LEVEL, 32'h1234_5678);
    chk("R5 raw write ignores mask", pin_out, 32'h1234_5678);
    wr(A_DIR, 32'h0000_FFFF);
    pin_in = 32'hCAFE_BEEF;
    settle();
    rd(A_LEVEL, v); chk("R5 raw read mixes levels", v, 32'hCAFE_5678);
  endtask

  task automatic t_sync();
    logic [NP-1:0] v;
    wr(A_DIR, 32'h0);
    settle();
    @(negedge clk);
    pin_in   = 32'h0F0F_0F0F;
    bus_addr = A_LEVEL;
    bus_re   = 1'b1;
    @(negedge clk);
    v      = bus_rdata;
    bus_re = 1'b0;
    chk("R6 same-cycle change unseen", v, 32'hCAFE_BEEF);
    repeat (2) @(negedge clk);
    rd(A_LEVEL, v); chk("R6 change seen later", v, 32'h0F0F_0F0F);
  endtask

  task automatic t_masked();
    logic [NP-1:0] v;
    wr(A_MASK, 32'h00FF_00FF);
    wr(A_LEVEL, 32'h0);
    wr(A_MLEVEL, 32'hFFFF_FFFF);
    chk("R7 masked write", pin_out, 32'hFF00_FF00);
    rd(A_MASK, v); chk("R7 mask read", v, 32'h00FF_00FF);
    wr(A_DIR, 32'hFFFF_FFFF);
    rd(A_MLEVEL, v); chk("R7 masked read", v, 32'hFF00_FF00);
    wr(A_LEVEL, 32'h00FF_00FF);
    rd(A_MLEVEL, v); chk("R7 masked bits read zero", v, 32'h0);
  endtask

  task automatic t_set();
    logic [NP-1:0] v;
    wr(A_DIR, 32'h0);
    pin_in = 32'h0;
    wr(A_LEVEL, 32'h0000_000F);
    wr(A_SET, 32'h00F0_00F0);
    chk("R8 set strobe", pin_out, 32'h00F0_00FF);
    settle();
    rd(A_SET, v); chk("R8 set read returns latch", v, 32'h00F0_00FF);
  endtask

  task automatic t_clr_tgl();
    logic [NP-1:0] v;
    wr(A_CLR, 32'h0000_000F);
    chk("R9 clear strobe", pin_out, 32'h00F0_00F0);
    wr(A_TGL, 32'hFF00_00F0);
    chk("R9 toggle strobe", pin_out, 32'hFFF0_0000);
    rd(A_CLR, v); chk("R9 clear read zero", v, 32'h0);
    rd(A_TGL, v); chk("R9 toggle read zero", v, 32'h0);
  endtask

  task automatic t_dirops();
    logic [NP-1:0] v;
    wr(A_DIR, 32'h0);
    wr(A_DSET, 32'h0000_00F0);
    chk("R10 dir set", pin_oe, 32'h0000_00F0);
    wr(A_DCLR, 32'h0000_0030);
    chk("R10 dir clear", pin_oe, 32'h0000_00C0);
    wr(A_DTGL, 32'h0000_0F0F);
    chk("R10 dir toggle", pin_oe, 32'h0000_0FCF);
    chk("R10 latch untouched", pin_out, 32'hFFF0_0000);
    rd(A_DSET, v); chk("R10 dirset read zero", v, 32'h0);
    rd(A_DCLR, v); chk("R10 dirclr read zero", v, 32'h0);
    rd(A_DTGL, v); chk("R10 dirtgl read zero", v, 32'h0);
  endtask

  task automatic t_unmapped();
    logic [NP-1:0] v;
    logic [AW-1:0] holes [5] = '{14'h2500, 14'h3000, 14'h0020, 14'h2004, 14'h1001};
    for (int i = 0; i < 5; i++) begin
      wr(holes[i], 32'hFFFF_FFFF);
      chk("R11 latch unchanged", pin_out, 32'hFFF0_0000);
      chk("R11 dir unchanged", pin_oe, 32'h0000_0FCF);
      rd(holes[i], v); chk("R11 read zero", v, 32'h0);
    end
    rd(A_MASK, v); chk("R11 mask unchanged", v, 32'h00FF_00FF);
  endtask

  task automatic t_latency();
    logic [NP-1:0] v;
    rd(A_DIR, v); chk("R12 read data next cycle", v, 32'h0000_0FCF);
    @(negedge clk);
    chk("R12 idle rdata zero", bus_rdata, 32'h0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_byte();
    t_word();
    t_dir();
    t_raw();
    t_sync();
    t_masked();
    t_set();
    t_clr_tgl();
    t_dirops();
    t_unmapped();
    t_latency();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule